// File: doc/BRIEF.md
# Link Start and Resynchronisation Controller

This block brings up a point-to-point, 16-bit, half-duplex word link between two identical peers, and brings it back after errors. On a start command it places a start-request word in its output word register and pulses an attention strobe to the partner. It then waits for a start-acknowledge word. The peer that receives the acknowledge becomes primary. The peer that answers a request becomes secondary. The role stays in force until the next start exchange, and message-level logic uses it later to settle conflicts over the link.

Both peers behave the same way, so two start attempts can collide. A peer that is waiting for an acknowledge and sees a request ignores it. It counts a failed attempt and backs off for a pseudo-random number of timeout ticks, taken from a 16-bit LFSR, before it tries again. A peer that is backing off answers any request it sees, so the collision resolves. A wait with no answer for a set number of ticks is also a failed attempt. After a set number of consecutive failures the block raises a sticky link-down flag, and only a reinit pulse clears it.

States: INACTIVE (not started), AWAIT_ACK (request sent, waiting for the answer), BACKOFF (random delay before a retry), ACTIVE (protocol running, role valid), DOWN (too many failures). Transitions:
- INACTIVE goes to AWAIT_ACK on start_cmd.
- INACTIVE, BACKOFF and DOWN go to ACTIVE as secondary on a received request.
- AWAIT_ACK goes to ACTIVE as primary on an acknowledge.
- AWAIT_ACK goes to BACKOFF on a collision or a timeout.
- AWAIT_ACK goes to DOWN on the last allowed failure.
- BACKOFF goes to AWAIT_ACK when its delay expires.
- ACTIVE stays in ACTIVE and becomes secondary on a request.
- ACTIVE goes to AWAIT_ACK on start_cmd.
- Any state goes to INACTIVE on reinit.

Top module: `link_start_ctrl`

## Requirements
- R1: In INACTIVE or ACTIVE, a start_cmd pulse causes tx_word = 16'h8400 (the start request: bit 15 marks a non-count word, bit 10 is the start flag) and a one-cycle tx_strobe in the clock after the command is sampled. The block then waits for an acknowledge.
- R2: A received word (rx_valid high) with bit 10 set counts as a start request, whatever its other bits are, including status bits that come with it. In INACTIVE, BACKOFF, ACTIVE or DOWN, such a word causes tx_word = 16'hA003 (bit 13 is the acknowledge flag, low byte 3) with one tx_strobe. link_up becomes 1 and is_primary becomes 0, all in the clock after the word.
- R3: While waiting, a received word with bit 13 set, bit 10 clear and low byte 8'h03 makes link_up 1 and is_primary 1 with no transmission. In every state, any word with bit 10 clear that is not of that form has no effect.
- R4: A start request received while waiting is not answered. After a delay of 1 to 2^BACKOFF_BITS tick pulses (1 to 64 by default), the block sends the start request again.
- R5: If exactly TIMEOUT_TICKS tick pulses arrive while waiting with no acknowledge, the attempt fails: after TIMEOUT_TICKS-1 ticks an acknowledge is still accepted, and after TIMEOUT_TICKS ticks it is ignored.
- R6: On the MAX_FAILS-th consecutive failed attempt (timeout or collision), link_down goes to 1 and link_up stays 0. No further start request is sent, and start_cmd is ignored.
- R7: link_down stays 1 until reinit. In DOWN, a received start request is still answered with 16'hA003, and the block moves to secondary ACTIVE with link_down still 1.
- R8: A reinit pulse returns the block to INACTIVE in the next clock with link_up, is_primary and link_down all 0, and clears the failure count.
- R9: In ACTIVE the role is held until a start word is exchanged. start_cmd has no effect while waiting or backing off.
- R10: After reset: link_up, is_primary, link_down and tx_strobe are 0 and tx_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_cmd | input | 1 | Pulse: begin or restart the start handshake |
| reinit | input | 1 | Pulse: clear link-down and return to INACTIVE |
| tick | input | 1 | Timeout time-base pulse |
| rx_word | input | 16 | Word received from the partner |
| rx_valid | input | 1 | One-cycle attention pulse qualifying rx_word |
| tx_word | output | 16 | Output word register to the partner |
| tx_strobe | output | 1 | One-cycle attention pulse to the partner |
| link_up | output | 1 | Protocol active |
| is_primary | output | 1 | Active and holding the primary role |
| link_down | output | 1 | Sticky: failure limit reached |

## Verification
A wrong state shows at the ports within one clock of the next received word or command. A block stuck in the wrong state would, for example, answer a start request when it should ignore it, miss a tx_strobe, or show the wrong role on is_primary. Timer and failure-count faults show up as an acknowledge accepted or refused on the wrong tick, or as a wrong number of retries before link_down. The bench therefore sweeps the full range of control bytes and low bytes against the request and acknowledge decoders. It also places acknowledges exactly on either side of the timeout boundary, and counts the requests sent on the way to link-down.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef enum logic [2:0] {
        ST_INACTIVE,
        ST_AWAIT_ACK,
        ST_BACKOFF,
        ST_ACTIVE,
        ST_DOWN
    } lsc_state_t;

    // Words exchanged with the partner
    localparam logic [15:0] WORD_START_REQ = 16'h8400;
    localparam logic [15:0] WORD_START_ACK = 16'hA003;

    // Decode masks: start flag on bit 10; acknowledge = bit 13, bit 10 clear, low byte 3
    localparam logic [15:0] MASK_START = 16'h0400;
    localparam logic [15:0] MASK_ACK   = 16'h24FF;
    localparam logic [15:0] MATCH_ACK  = 16'h2003;
endpackage

// File: rtl/lsc_word_decode.sv
module lsc_word_decode
    import lsc_pkg::*;
(
    input  logic [15:0] word,
    input  logic        valid,
    output logic        is_req,
    output logic        is_ack
);
    always_comb begin
        is_req = valid && ((word & MASK_START) != 16'h0000);
        is_ack = valid && ((word & MASK_ACK) == MATCH_ACK);
    end
endmodule

// File: rtl/lsc_lfsr.sv
module lsc_lfsr #(
    parameter int          OUT_W = 6,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [15:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= SEED;
        end else if (sr[0]) begin
            sr <= (sr >> 1) ^ TAPS;
        end else begin
            sr <= sr >> 1;
        end
    end

    assign rnd = sr[OUT_W-1:0];
endmodule

// File: rtl/link_start_ctrl.sv
module link_start_ctrl
    import lsc_pkg::*;
#(
    parameter int          TIMEOUT_TICKS = 16,
    parameter int          MAX_FAILS     = 8,
    parameter int          BACKOFF_BITS  = 6,
    parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_cmd,
    input  logic        reinit,
    input  logic        tick,
    input  logic [15:0] rx_word,
    input  logic        rx_valid,
    output logic [15:0] tx_word,
    output logic        tx_strobe,
    output logic        link_up,
    output logic        is_primary,
    output logic        link_down
);
    localparam int TMR_W  = $clog2(TIMEOUT_TICKS + 1);
    localparam int FAIL_W = $clog2(MAX_FAILS + 1);
    localparam int BO_W   = BACKOFF_BITS + 1;

    lsc_state_t              state, nxt;
    logic [TMR_W-1:0]        tmr;
    logic [FAIL_W-1:0]       fails;
    logic [BO_W-1:0]         bo_cnt;
    logic                    primary_q, down_q;
    logic [BACKOFF_BITS-1:0] rnd;
    logic                    rx_req, rx_ack;
    logic                    send_req, send_ack, fail_evt, set_pri, set_sec;
    logic                    tmr_last, fail_last, bo_last;

    lsc_word_decode u_dec (
        .word  (rx_word),
        .valid (rx_valid),
        .is_req(rx_req),
        .is_ack(rx_ack)
    );

    lsc_lfsr #(.OUT_W(BACKOFF_BITS), .SEED(LFSR_SEED)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .rnd  (rnd)
    );

    assign tmr_last  = (tmr == TMR_W'(TIMEOUT_TICKS - 1));
    assign fail_last = (fails == FAIL_W'(MAX_FAILS - 1));
    assign bo_last   = (bo_cnt == BO_W'(1));

    // Next state and transition actions
    always_comb begin
        nxt      = state;
        send_req = 1'b0;
        send_ack = 1'b0;
        fail_evt = 1'b0;
        set_pri  = 1'b0;
        set_sec  = 1'b0;
        unique case (state)
            ST_INACTIVE: begin
                if (rx_req) begin
                    send_ack = 1'b1; set_sec = 1'b1; nxt = ST_ACTIVE;
                end else if (start_cmd) begin
                    send_req = 1'b1; nxt = ST_AWAIT_ACK;
                end
            end
            ST_AWAIT_ACK: begin
                if (rx_ack) begin
                    set_pri = 1'b1; nxt = ST_ACTIVE;
                end else if (rx_req || (tick && tmr_last)) begin
                    fail_evt = 1'b1;
                    nxt      = fail_last ? ST_DOWN : ST_BACKOFF;
                end
            end
            ST_BACKOFF: begin
                if (rx_req) begin
                    send_ack = 1'b1; set_sec = 1'b1; nxt = ST_ACTIVE;
                end else if (tick && bo_last) begin
                    send_req = 1'b1; nxt = ST_AWAIT_ACK;
                end
            end
            ST_ACTIVE: begin
                if (rx_req) begin
                    send_ack = 1'b1; set_sec = 1'b1;
                end else if (start_cmd) begin
                    send_req = 1'b1; nxt = ST_AWAIT_ACK;
                end
            end
            ST_DOWN: begin
                if (rx_req) begin
                    send_ack = 1'b1; set_sec = 1'b1; nxt = ST_ACTIVE;
                end
            end
            default: nxt = ST_INACTIVE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_INACTIVE;
            tmr       <= '0;
            fails     <= '0;
            bo_cnt    <= '0;
            primary_q <= 1'b0;
            down_q    <= 1'b0;
            tx_word   <= '0;
            tx_strobe <= 1'b0;
        end else if (reinit) begin
            state     <= ST_INACTIVE;
            tmr       <= '0;
            fails     <= '0;
            bo_cnt    <= '0;
            primary_q <= 1'b0;
            down_q    <= 1'b0;
            tx_strobe <= 1'b0;
        end else begin
            state     <= nxt;
            tx_strobe <= send_req || send_ack;
            if (send_req) begin
                tx_word <= WORD_START_REQ;
            end else if (send_ack) begin
                tx_word <= WORD_START_ACK;
            end
            if (send_req) begin
                tmr <= '0;
            end else if (state == ST_AWAIT_ACK && tick) begin
                tmr <= tmr + TMR_W'(1);
            end
            if (fail_evt && !fail_last) begin
                bo_cnt <= {1'b0, rnd} + BO_W'(1);
            end else if (state == ST_BACKOFF && tick) begin
                bo_cnt <= bo_cnt - BO_W'(1);
            end
            if (set_pri || set_sec) begin
                fails <= '0;
            end else if (fail_evt) begin
                fails <= fails + FAIL_W'(1);
            end
            if (fail_evt && fail_last) begin
                down_q <= 1'b1;
            end
            if (set_pri) begin
                primary_q <= 1'b1;
            end else if (set_sec) begin
                primary_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        link_up    = (state == ST_ACTIVE);
        is_primary = (state == ST_ACTIVE) && primary_q;
        link_down  = down_q;
    end
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reinit,
    input logic        rx_valid,
    input logic [15:0] tx_word,
    input logic        tx_strobe,
    input logic        link_up,
    input logic        is_primary,
    input logic        link_down
);
    AST_LEGAL_TX_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> (tx_word == 16'h8400 || tx_word == 16'hA003)); // R1

    AST_SECONDARY_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_up) && !is_primary) |-> (tx_strobe && tx_word == 16'hA003)); // R2

    AST_PRIMARY_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_primary) |-> $past(rx_valid)); // R3

    AST_DOWN_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_down) |-> !link_up); // R6

    AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_down && !reinit) |=> link_down); // R7

    AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (!link_down && !link_up && !is_primary)); // R8
endmodule

bind link_start_ctrl lsc_checker u_lsc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reinit    (reinit),
    .rx_valid  (rx_valid),
    .tx_word   (tx_word),
    .tx_strobe (tx_strobe),
    .link_up   (link_up),
    .is_primary(is_primary),
    .link_down (link_down)
);

// File: tb/link_start_ctrl_test.sv
module link_start_ctrl_test;
    localparam int TMO   = 16;
    localparam int FAILS = 8;
    localparam logic [15:0] REQ = 16'h8400;
    localparam logic [15:0] ACK = 16'hA003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_cmd = 1'b0, reinit = 1'b0, tick = 1'b0, rx_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic [15:0] tx_word;
    logic        tx_strobe, link_up, is_primary, link_down;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    link_start_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .reinit(reinit),
        .tick(tick), .rx_word(rx_word), .rx_valid(rx_valid), .tx_word(tx_word),
        .tx_strobe(tx_strobe), .link_up(link_up), .is_primary(is_primary),
        .link_down(link_down)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; outputs are sampled afterwards
    task automatic step(input bit sc, input bit ri, input bit tk, input bit rv, input logic [15:0] w);
        @(negedge clk);
        start_cmd = sc; reinit = ri; tick = tk; rx_valid = rv; rx_word = w;
        @(negedge clk);
        start_cmd = 1'b0; reinit = 1'b0; tick = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic do_reinit();
        step(0, 1, 0, 0, '0);
    endtask

    task automatic do_start(input string req);
        step(1, 0, 0, 0, '0);
        chk(tx_strobe && tx_word == REQ, req, {tx_strobe, tx_word}, {1'b1, REQ});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!link_up && !is_primary && !link_down && !tx_strobe && tx_word == 0, "R10",
            {link_up, is_primary, link_down, tx_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: sweep every control byte in INACTIVE; start flag alone decides
        for (int hb = 0; hb < 256; hb++) begin
            automatic logic [15:0] w = {hb[7:0], hb[7:0] ^ 8'h5A};
            automatic bit exp_req = hb[2];
            do_reinit();
            step(0, 0, 0, 1, w);
            chk(tx_strobe == exp_req && link_up == exp_req && !is_primary, "R2",
                {tx_strobe, link_up, is_primary}, {exp_req, exp_req, 1'b0});
            if (exp_req) chk(tx_word == ACK, "R2", tx_word, ACK);
        end

        // R3/R4: sweep words while waiting; only the acknowledge form makes primary
        for (int v = 0; v < 512; v++) begin
            automatic logic [7:0] hb = (v < 256) ? v[7:0] : 8'h20;
            automatic logic [7:0] lb = (v < 256) ? 8'h03 : v[7:0];
            automatic bit exp_ack = hb[5] && !hb[2] && (lb == 8'h03);
            do_reinit();
            do_start("R1");
            step(0, 0, 0, 1, {hb, lb});
            chk(link_up == exp_ack && is_primary == exp_ack && !tx_strobe, "R3",
                {link_up, is_primary, tx_strobe}, {exp_ack, exp_ack, 1'b0});
        end

        // R9: role held, start_cmd ignored while waiting
        do_reinit();
        do_start("R1");
        step(1, 0, 0, 0, '0);
        chk(!tx_strobe, "R9", tx_strobe, 0);
        step(0, 0, 0, 1, ACK);
        chk(is_primary && link_up, "R3", {link_up, is_primary}, 2'b11);
        step(0, 0, 0, 1, 16'hA103);
        step(0, 0, 0, 1, 16'h1234);
        chk(is_primary && link_up && !tx_strobe, "R9", {link_up, is_primary, tx_strobe}, 3'b110);
        // R2: restart request combined with status bits, while active as primary
        step(0, 0, 0, 1, 16'h9420);
        chk(tx_strobe && tx_word == ACK && link_up && !is_primary, "R2",
            {tx_strobe, link_up, is_primary}, 3'b110);
        // R1: restart from ACTIVE
        do_start("R1");
        chk(!link_up, "R1", link_up, 0);

        // R5: acknowledge still accepted after TMO-1 ticks
        do_reinit();
        do_start("R1");
        for (int i = 0; i < TMO - 1; i++) step(0, 0, 1, 0, '0);
        step(0, 0, 0, 1, ACK);
        chk(is_primary, "R5", is_primary, 1);
        // R5: ignored after TMO ticks
        do_reinit();
        do_start("R1");
        for (int i = 0; i < TMO; i++) step(0, 0, 1, 0, '0);
        step(0, 0, 0, 1, ACK);
        chk(!link_up && !tx_strobe, "R5", {link_up, tx_strobe}, 0);

        // R4: collision then random backoff of 1..64 ticks
        for (int trial = 0; trial < 6; trial++) begin
            automatic int n = 0;
            automatic bit seen = 1'b0;
            do_reinit();
            repeat (trial * 3) step(0, 0, 0, 0, '0);
            do_start("R1");
            step(0, 0, 0, 1, REQ);
            chk(!tx_strobe && !link_up, "R4", {tx_strobe, link_up}, 0);
            for (int i = 0; i < 70 && !seen; i++) begin
                step(0, 0, 1, 0, '0);
                n++;
                if (tx_strobe) seen = 1'b1;
            end
            chk(seen && n >= 1 && n <= 64 && tx_word == REQ, "R4", n, 64);
            step(0, 0, 0, 1, ACK);
            chk(is_primary, "R4", is_primary, 1);
        end

        // R2: request during backoff is answered
        do_reinit();
        do_start("R1");
        step(0, 0, 0, 1, REQ);
        step(0, 0, 0, 1, REQ);
        chk(tx_strobe && tx_word == ACK && link_up && !is_primary, "R2",
            {tx_strobe, link_up, is_primary}, 3'b110);

        // R6: repeated timeouts lead to link_down after FAILS requests
        begin
            automatic int reqs = 0;
            do_reinit();
            do_start("R1");
            reqs = 1;
            for (int i = 0; i < 2000 && !link_down; i++) begin
                step(0, 0, 1, 0, '0);
                if (tx_strobe) reqs++;
            end
            chk(link_down && !link_up, "R6", {link_down, link_up}, 2'b10);
            chk(reqs == FAILS, "R6", reqs, FAILS);
            reqs = 0;
            for (int i = 0; i < 200; i++) begin
                step(i == 5, 0, 1, 0, '0);
                if (tx_strobe) reqs++;
            end
            chk(reqs == 0 && link_down, "R6", reqs, 0);
        end

        // R7: request in DOWN answered, link_down stays
        step(0, 0, 0, 1, 16'h9408);
        chk(tx_strobe && tx_word == ACK && link_up && !is_primary && link_down, "R7",
            {tx_strobe, link_up, is_primary, link_down}, 4'b1101);
        step(0, 0, 1, 0, '0);
        chk(link_down, "R7", link_down, 1);

        // R8: reinit clears everything
        do_reinit();
        chk(!link_down && !link_up && !is_primary, "R8", {link_down, link_up, is_primary}, 0);
        do_start("R8");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end
endmodule